// File: doc/BRIEF.md
# Write-Only I2C Volume Command Slave

This block is the control-port front end of a six-channel volume controller. It listens to a two-wire I2C bus, accepts write transactions addressed to the fixed 7-bit address 1000000, and delivers a 16-bit command word to the volume register logic. The upper byte of the word is a channel select mask and the lower byte is an attenuation code.

Both bus lines are brought into the system clock domain through a flop synchronizer and then edge-detected. START and STOP are recognised as SDA edges while SCL is high. Data bits are sampled on SCL rising edges. The acknowledge driver pulls SDA low, through an open-drain enable, during the ninth clock of every accepted byte. The word is committed together with a one-cycle strobe, and only once the third byte of a frame has been acknowledged.

Top module: `vol_cmd_i2c_slave`

## Requirements
- R1: After reset, `sda_oe` is 0, `cmd_valid` is 0 and `cmd_word` is 0.
- R2: A first byte of 0x80 (address 1000000 in bits 7..1, write bit 0 in bit 0) is acknowledged, which means `sda_oe` is 1 while SCL is high during the ninth clock.
- R3: A first byte carrying any other address, or a read bit of 1 (for example 0x81), is not acknowledged. The following bytes are also not acknowledged, and no word is committed until the next START.
- R4: Once the address has been accepted, each of the two data bytes is acknowledged. `sda_oe` is raised only while SCL is low.
- R5: `cmd_word` equals {second byte, third byte}, with the second byte in bits 15..8 and the third byte in bits 7..0.
- R6: `cmd_valid` is high for exactly one clock per complete frame. It never rises before the third byte's acknowledge clock has ended.
- R7: A STOP that arrives before the third byte has been acknowledged discards the partial data: `cmd_valid` stays low and `cmd_word` keeps its previous value.
- R8: A repeated START at any point restarts address matching at byte 0. This applies both mid-frame and after a rejected address.
- R9: After a committed frame, any further byte before STOP is not acknowledged and leaves `cmd_word` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin (wired-AND level) |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| cmd_word | output | 16 | Last committed command word (mask in 15..8, code in 7..0) |
| cmd_valid | output | 1 | One-cycle strobe marking a newly committed word |

## Verification
The assertions assume a bus master that keeps SCL low and high for several system clocks, so that each synchronized SCL edge is seen as a separate event. They also assume that SDA changes only while SCL is low, except where it forms a START or STOP. The bench master holds every SCL phase for at least five system clocks and moves SDA only in the middle of the low phase. This keeps both edges well clear of the synchronizer latency, and the acknowledge that the slave drives is read back through a wired-AND model of the line.

// File: rtl/vcmd_pkg.sv
package vcmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACK_SETUP,
        ST_ACK_HOLD,
        ST_IGNORE,
        ST_DONE
    } fsm_t;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/vcmd_line_sync.sv
module vcmd_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic level,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d       = q;
        d.chain = {q.chain[STAGES-2:0], line_in};
        d.prev  = q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign level = q.chain[STAGES-1];
    assign rise  = level & ~q.prev;
    assign fall  = ~level & q.prev;

endmodule

// File: rtl/vcmd_bus_events.sv
module vcmd_bus_events (
    input  logic scl_lvl,
    input  logic scl_rise,
    input  logic scl_fall,
    input  logic sda_lvl,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_ev,
    output logic stop_ev,
    output logic bit_rise,
    output logic bit_fall,
    output logic bit_val
);
    logic scl_steady_high;

    always_comb begin
        scl_steady_high = scl_lvl & ~scl_rise;
        start_ev        = scl_steady_high & sda_fall;
        stop_ev         = scl_steady_high & sda_rise;
        bit_rise        = scl_rise;
        bit_fall        = scl_fall;
        bit_val         = sda_lvl;
    end

endmodule

// File: rtl/vcmd_frame_engine.sv
module vcmd_frame_engine
    import vcmd_pkg::*;
#(
    parameter logic [6:0]  ADDR       = 7'b1000000,
    parameter int unsigned DATA_BYTES = 2,
    localparam int unsigned WORD_W    = BYTE_W * DATA_BYTES,
    localparam int unsigned IDX_W     = $clog2(DATA_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              bit_rise,
    input  logic              bit_fall,
    input  logic              bit_val,
    input  logic              scl_lvl,
    output logic              sda_oe,
    output logic [WORD_W-1:0] word,
    output logic              valid
);
    typedef struct packed {
        fsm_t              st;
        logic [2:0]        bit_cnt;
        logic [IDX_W-1:0]  byte_idx;
        logic [7:0]        shreg;
        logic [WORD_W-1:0] asm_w;
        logic              oe;
        logic [WORD_W-1:0] word;
        logic              valid;
    } eng_t;

    eng_t q, d;

    always_comb begin
        logic [7:0]        shift_v;
        logic [WORD_W+7:0] cat_v;
        d       = q;
        d.valid = 1'b0;
        shift_v = {q.shreg[6:0], bit_val};
        cat_v   = {q.asm_w, shift_v};
        if (stop_ev) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (start_ev) begin
            d.st       = ST_RECV;
            d.bit_cnt  = '0;
            d.byte_idx = '0;
            d.oe       = 1'b0;
            d.asm_w    = '0;
        end else begin
            case (q.st)
                ST_RECV: begin
                    if (bit_rise) begin
                        d.shreg   = shift_v;
                        d.bit_cnt = q.bit_cnt + 3'd1;
                        if (q.bit_cnt == 3'd7) begin
                            if (q.byte_idx == '0) begin
                                d.st = (shift_v == {ADDR, 1'b0}) ? ST_ACK_SETUP : ST_IGNORE;
                            end else begin
                                d.asm_w = cat_v[WORD_W-1:0];
                                d.st    = ST_ACK_SETUP;
                            end
                        end
                    end
                end
                ST_ACK_SETUP: begin
                    if (bit_fall) begin
                        d.oe = 1'b1;
                        d.st = ST_ACK_HOLD;
                    end
                end
                ST_ACK_HOLD: begin
                    if (bit_fall) begin
                        d.oe      = 1'b0;
                        d.bit_cnt = '0;
                        if (q.byte_idx == IDX_W'(DATA_BYTES)) begin
                            d.word  = q.asm_w;
                            d.valid = 1'b1;
                            d.st    = ST_DONE;
                        end else begin
                            d.byte_idx = q.byte_idx + IDX_W'(1);
                            d.st       = ST_RECV;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;
    assign word   = q.word;
    assign valid  = q.valid;

    // R6: the commit strobe lasts a single cycle
    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R6: the commit coincides with releasing the final acknowledge
    p_valid_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(sda_oe));

    // R4: the acknowledge driver only engages while SCL is low
    p_oe_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);

    // R3: a rejected frame never drives the line
    p_ignore_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IGNORE) |-> !sda_oe);

    // R7: the output word moves only on a commit
    p_word_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable(word));

endmodule

// File: rtl/vol_cmd_i2c_slave.sv
module vol_cmd_i2c_slave #(
    parameter logic [6:0]  ADDR        = 7'b1000000,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DATA_BYTES  = 2,
    localparam int unsigned WORD_W     = 8 * DATA_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic [WORD_W-1:0] cmd_word,
    output logic              cmd_valid
);
    localparam int unsigned N_LINES = 2;  // index 0: SCL, index 1: SDA

    logic [N_LINES-1:0] raw;
    logic [N_LINES-1:0] lvl, rs, fl;
    logic start_ev, stop_ev, bit_rise, bit_fall, bit_val;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        vcmd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_in (raw[g]),
            .level   (lvl[g]),
            .rise    (rs[g]),
            .fall    (fl[g])
        );
    end

    vcmd_bus_events u_events (
        .scl_lvl  (lvl[0]),
        .scl_rise (rs[0]),
        .scl_fall (fl[0]),
        .sda_lvl  (lvl[1]),
        .sda_rise (rs[1]),
        .sda_fall (fl[1]),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .bit_rise (bit_rise),
        .bit_fall (bit_fall),
        .bit_val  (bit_val)
    );

    vcmd_frame_engine #(.ADDR(ADDR), .DATA_BYTES(DATA_BYTES)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .bit_rise (bit_rise),
        .bit_fall (bit_fall),
        .bit_val  (bit_val),
        .scl_lvl  (lvl[0]),
        .sda_oe   (sda_oe),
        .word     (cmd_word),
        .valid    (cmd_valid)
    );

endmodule

// File: tb/tb_vol_cmd_i2c_slave.sv
`timescale 1ns/1ps
module tb_vol_cmd_i2c_slave;
    localparam int Q = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, cmd_valid;
    logic [15:0] cmd_word;
    wire  sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int fails  = 0;
    int vcount = 0;
    logic [15:0] vword = '0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    vol_cmd_i2c_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_oe(sda_oe), .cmd_word(cmd_word), .cmd_valid(cmd_valid)
    );

    always @(negedge clk) if (cmd_valid) begin
        vcount = vcount + 1;
        vword  = cmd_word;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic qw(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qw(1); scl_m = 1'b1; qw(1);
        sda_m = 1'b0; qw(2); scl_m = 1'b0; qw(1);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw(1); scl_m = 1'b1; qw(1);
        sda_m = 1'b1; qw(3);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qw(1); scl_m = 1'b1; qw(2); scl_m = 1'b0; qw(1);
        end
        sda_m = 1'b1; qw(1); scl_m = 1'b1; qw(1);
        ack = ~sda_line;
        qw(1); scl_m = 1'b0; qw(1);
    endtask

    task automatic frame(input logic [7:0] a, input logic [7:0] b2, input logic [7:0] b3,
                         output bit k0, output bit k1, output bit k2);
        bus_start();
        send_byte(a, k0);
        send_byte(b2, k1);
        send_byte(b3, k2);
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        bit k0, k1, k2, k3;
        int v0;
        logic [15:0] prev;
        repeat (4) @(negedge clk);
        // R1: reset values
        chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
        chk(cmd_valid == 1'b0, "R1 cmd_valid", cmd_valid, 0);
        chk(cmd_word == 16'h0, "R1 cmd_word", cmd_word, 0);
        rst_n = 1'b1;
        qw(2);

        // R2 R4 R5 R6: basic frame, checked mid-way
        v0 = vcount;
        bus_start();
        send_byte(8'h80, k0);
        chk(k0, "R2 address ack", k0, 1);
        send_byte(8'h3F, k1);
        chk(k1, "R4 first data ack", k1, 1);
        chk(vcount == v0, "R6 no strobe before third byte", vcount - v0, 0);
        send_byte(8'h10, k2);
        chk(k2, "R4 second data ack", k2, 1);
        bus_stop();
        chk(vcount - v0 == 1, "R6 one strobe cycle", vcount - v0, 1);
        chk(cmd_word == 16'h3F10, "R5 word", cmd_word, 16'h3F10);

        // R3 R2: sweep of all addresses with write bit
        for (int a = 0; a < 128; a++) begin
            logic [7:0] b2, b3;
            b2 = 8'(a * 3 + 1);
            b3 = 8'(255 - a);
            v0 = vcount; prev = cmd_word;
            frame({7'(a), 1'b0}, b2, b3, k0, k1, k2);
            if (a == 64) begin
                chk(k0 && k1 && k2, "R2 sweep match acks", {k0, k1, k2}, 7);
                chk(vcount - v0 == 1 && cmd_word == {b2, b3}, "R5 sweep match word", cmd_word, {b2, b3});
            end else begin
                chk(!k0 && !k1 && !k2, "R3 sweep mismatch acks", {k0, k1, k2}, 0);
                chk(vcount == v0 && cmd_word == prev, "R3 sweep mismatch word", cmd_word, prev);
            end
        end

        // R3: read bit
        v0 = vcount; prev = cmd_word;
        frame(8'h81, 8'h01, 8'h02, k0, k1, k2);
        chk(!k0 && !k1 && !k2, "R3 read bit acks", {k0, k1, k2}, 0);
        chk(vcount == v0 && cmd_word == prev, "R3 read bit word", cmd_word, prev);

        // R5 R6: data sweep
        for (int i = 0; i < 48; i++) begin
            logic [7:0] b2, b3;
            b2 = 8'(i * 5 + 7);
            b3 = 8'(i * 37 + 3);
            v0 = vcount;
            frame(8'h80, b2, b3, k0, k1, k2);
            chk(k0 && k1 && k2, "R4 data sweep acks", {k0, k1, k2}, 7);
            chk(vcount - v0 == 1, "R6 data sweep strobe", vcount - v0, 1);
            chk(cmd_word == {b2, b3} && vword == {b2, b3}, "R5 data sweep word", cmd_word, {b2, b3});
        end

        // R7: STOP after the first data byte
        v0 = vcount; prev = cmd_word;
        bus_start(); send_byte(8'h80, k0); send_byte(8'h12, k1); bus_stop();
        chk(vcount == v0 && cmd_word == prev, "R7 early stop after byte 2", cmd_word, prev);
        // R7: STOP right after the address
        bus_start(); send_byte(8'h80, k0); bus_stop();
        chk(vcount == v0 && cmd_word == prev, "R7 early stop after address", cmd_word, prev);

        // R8: repeated START mid-frame
        v0 = vcount;
        bus_start(); send_byte(8'h80, k0); send_byte(8'hAA, k1);
        bus_start(); send_byte(8'h80, k0); send_byte(8'h05, k1); send_byte(8'h20, k2);
        bus_stop();
        chk(k0 && k1 && k2, "R8 restart acks", {k0, k1, k2}, 7);
        chk(vcount - v0 == 1 && cmd_word == 16'h0520, "R8 restart word", cmd_word, 16'h0520);
        // R8: repeated START after rejected address
        v0 = vcount;
        bus_start(); send_byte(8'h22, k0);
        chk(!k0, "R8 rejected address nack", k0, 0);
        bus_start(); send_byte(8'h80, k0); send_byte(8'h21, k1); send_byte(8'h4F, k2);
        bus_stop();
        chk(k0 && k1 && k2 && cmd_word == 16'h214F && vcount - v0 == 1, "R8 after reject", cmd_word, 16'h214F);

        // R9: extra byte after commit
        v0 = vcount;
        bus_start(); send_byte(8'h80, k0); send_byte(8'h11, k1); send_byte(8'h22, k2);
        send_byte(8'h33, k3);
        bus_stop();
        chk(!k3, "R9 extra byte nack", k3, 0);
        chk(cmd_word == 16'h1122 && vcount - v0 == 1, "R9 word kept", cmd_word, 16'h1122);
        chk(sda_oe == 1'b0, "R4 line released at idle", sda_oe, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule